// File: doc/BRIEF.md
# Configuration Cycle Bus-Number Router

This block is the part of a bus-to-bus bridge that decides what to do with each configuration request arriving on the upstream (primary) side. A request is a 32-bit address, a bit that tells a Type 0 request from a Type 1 request, and a valid strobe. Three programmable bus-number registers set how the bridge routes requests: the number of the upstream bus, the number of the bus directly below the bridge, and the highest bus number reachable below it.

For every request the router gives one verdict. A Type 0 request is claimed for the bridge's own header. A Type 1 request that targets the bus directly below the bridge is rewritten into a Type 0 address with a one-hot device-select field. A Type 1 request for a deeper bus inside the claimed range is passed on unchanged. Anything else is dropped. The verdict and the outgoing address appear one clock after the request. Data transfer and completion handling are done elsewhere.

Top module: `cfgr_router`

## Requirements
- R1: After reset, all three bus-number registers read zero and `rsp_valid` is low. While the downstream bus number is zero, every Type 1 request gets route code 0 (drop).
- R2: A Type 0 request (`req_type1` = 0) gets route code 3 (local). It is never sent downstream: `rsp_addr` is zero and `rsp_type1` is low.
- R3: A Type 1 request whose bus field `req_addr[23:16]` is below the downstream number or above the highest number gets route code 0 (drop). If the highest number is below the downstream number, every Type 1 request is dropped.
- R4: A Type 1 request whose bus field equals the downstream number gets route code 1 (convert). Its `rsp_addr[10:2]` equals `req_addr[10:2]`, `rsp_addr[1:0]` is 00, and `rsp_type1` is low.
- R5: A Type 1 request whose bus field is above the downstream number and at or below the highest number gets route code 2 (pass). Its `rsp_addr` equals `req_addr` bit for bit, and `rsp_type1` is high.
- R6: In a converted address, `rsp_addr[31:11]` has exactly one set bit, at position 11 plus the device field `req_addr[15:11]`.
- R7: A request that would be converted but has a device field above 20 is dropped instead (route code 0, `rsp_addr` zero), and `rsp_err` is high for that response. In every other case `rsp_err` is low.
- R8: When the highest number is 0xFF, every bus number from the downstream number through 0xFF is claimed (converted or passed).
- R9: Each request with `req_valid` high produces exactly one response with `rsp_valid` high on the next clock. In a cycle after one with no request, `rsp_valid` and `rsp_err` are low.
- R10: A write with `bus_wr` high loads `bus_wdata` into the register picked by `bus_sel` (0 upstream, 1 downstream, 2 highest). Select value 3 changes nothing. The new value shows on the register outputs and applies to requests from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Configuration request present this cycle |
| req_type1 | input | 1 | 1 for a Type 1 request, 0 for Type 0 |
| req_addr | input | 32 | Request address (bus [23:16], device [15:11], function [10:8], register [7:2]) |
| bus_wr | input | 1 | Write strobe for the bus-number registers |
| bus_sel | input | 2 | Register select: 0 upstream, 1 downstream, 2 highest, 3 none |
| bus_wdata | input | 8 | Value to write |
| pri_bus | output | 8 | Upstream bus number register |
| sec_bus | output | 8 | Downstream bus number register |
| sub_bus | output | 8 | Highest reachable bus number register |
| rsp_valid | output | 1 | Response present |
| rsp_route | output | 2 | 0 drop, 1 convert, 2 pass, 3 local |
| rsp_addr | output | 32 | Outgoing address; zero when dropped or local |
| rsp_type1 | output | 1 | Outgoing request is Type 1 |
| rsp_err | output | 1 | Converted request dropped because its device number is too high |

## Verification
Directed cases use upstream 1, downstream 3, highest 4. Bus 3 must be converted, bus 4 passed, and buses 2 and 5 dropped, which separates each edge of the range compare. Device numbers 0, 20 and 21 test both ends of the one-hot field and the error drop. The same bus numbers are also tried with the downstream number at zero, with the highest number at 0xFF, and with the highest number below the downstream number, so that the empty-range and open-ended cases cannot pass by accident. Random requests against randomly reprogrammed registers, with bus numbers kept near the programmed range and device numbers spread over the whole field, then exercise every route against a bench model of the same rules.

// File: rtl/cfgr_pkg.sv
package cfgr_pkg;

    // verdict codes carried on rsp_route
    typedef enum logic [1:0] {
        RT_DROP  = 2'd0,
        RT_TYPE0 = 2'd1,
        RT_PASS  = 2'd2,
        RT_LOCAL = 2'd3
    } route_e;

    // bus-number register select
    typedef enum logic [1:0] {
        SEL_UP   = 2'd0,
        SEL_DOWN = 2'd1,
        SEL_HIGH = 2'd2,
        SEL_NONE = 2'd3
    } bus_sel_e;

    // registered response bundle
    typedef struct packed {
        logic        valid;
        route_e      route;
        logic [31:0] addr;
        logic        type1;
        logic        err;
    } rsp_t;

    localparam logic [1:0] TYPE1_TAG = 2'b01;
    localparam logic [1:0] TYPE0_TAG = 2'b00;

endpackage

// File: rtl/cfgr_busnum.sv
module cfgr_busnum
    import cfgr_pkg::*;
#(
    parameter int BUS_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  logic [1:0]       sel,
    input  logic [BUS_W-1:0] wdata,
    output logic [BUS_W-1:0] up_num,
    output logic [BUS_W-1:0] down_num,
    output logic [BUS_W-1:0] high_num
);

    always_ff @(posedge clk) begin
        if (rst) begin
            up_num   <= '0;
            down_num <= '0;
            high_num <= '0;
        end else if (wr) begin
            case (bus_sel_e'(sel))
                SEL_UP:   up_num   <= wdata;
                SEL_DOWN: down_num <= wdata;
                SEL_HIGH: high_num <= wdata;
                default:  ;
            endcase
        end
    end

endmodule

// File: rtl/cfgr_decide.sv
module cfgr_decide
    import cfgr_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int BUS_W     = 8,
    parameter int BUS_LSB   = 16,
    parameter int DEV_W     = 5,
    parameter int IDSEL_LSB = 11
) (
    input  logic              type1,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BUS_W-1:0]  down_num,
    input  logic [BUS_W-1:0]  high_num,
    output route_e            route,
    output logic              dev_err
);

    localparam int DEV_LSB = IDSEL_LSB;
    localparam int MAX_DEV = ADDR_W - 1 - IDSEL_LSB;

    logic [BUS_W-1:0] bus_f;
    logic [DEV_W-1:0] dev_f;
    logic             in_range;
    logic             unset;

    assign bus_f    = addr[BUS_LSB +: BUS_W];
    assign dev_f    = addr[DEV_LSB +: DEV_W];
    assign unset    = (down_num == '0);
    assign in_range = (bus_f >= down_num) && (bus_f <= high_num);

    always_comb begin
        route   = RT_DROP;
        dev_err = 1'b0;
        if (!type1) begin
            route = RT_LOCAL;
        end else if (unset || !in_range) begin
            route = RT_DROP;
        end else if (bus_f == down_num) begin
            if (dev_f > DEV_W'(MAX_DEV)) begin
                route   = RT_DROP;
                dev_err = 1'b1;
            end else begin
                route = RT_TYPE0;
            end
        end else begin
            route = RT_PASS;
        end
    end

endmodule

// File: rtl/cfgr_t0_addr.sv
module cfgr_t0_addr
    import cfgr_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int DEV_W     = 5,
    parameter int IDSEL_LSB = 11
) (
    input  logic [ADDR_W-1:0] in_addr,
    output logic [ADDR_W-1:0] out_addr
);

    localparam int MAX_DEV = ADDR_W - 1 - IDSEL_LSB;

    logic [DEV_W-1:0] dev_f;
    logic [MAX_DEV:0] idsel;

    assign dev_f = in_addr[IDSEL_LSB +: DEV_W];

    for (genvar g = 0; g <= MAX_DEV; g++) begin : g_idsel
        assign idsel[g] = (dev_f == DEV_W'(g));
    end

    assign out_addr = {idsel, in_addr[IDSEL_LSB-1:2], TYPE0_TAG};

endmodule

// File: rtl/cfgr_router.sv
module cfgr_router
    import cfgr_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int BUS_W     = 8,
    parameter int BUS_LSB   = 16,
    parameter int DEV_W     = 5,
    parameter int IDSEL_LSB = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_type1,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              bus_wr,
    input  logic [1:0]        bus_sel,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  pri_bus,
    output logic [BUS_W-1:0]  sec_bus,
    output logic [BUS_W-1:0]  sub_bus,
    output logic              rsp_valid,
    output logic [1:0]        rsp_route,
    output logic [ADDR_W-1:0] rsp_addr,
    output logic              rsp_type1,
    output logic              rsp_err
);

    route_e            d_route;
    logic              d_err;
    logic [ADDR_W-1:0] t0_addr;
    logic [ADDR_W-1:0] nxt_addr;
    rsp_t              rsp_q;

    cfgr_busnum #(.BUS_W(BUS_W)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr       (bus_wr),
        .sel      (bus_sel),
        .wdata    (bus_wdata),
        .up_num   (pri_bus),
        .down_num (sec_bus),
        .high_num (sub_bus)
    );

    cfgr_decide #(
        .ADDR_W(ADDR_W), .BUS_W(BUS_W), .BUS_LSB(BUS_LSB),
        .DEV_W(DEV_W), .IDSEL_LSB(IDSEL_LSB)
    ) u_decide (
        .type1    (req_type1),
        .addr     (req_addr),
        .down_num (sec_bus),
        .high_num (sub_bus),
        .route    (d_route),
        .dev_err  (d_err)
    );

    cfgr_t0_addr #(
        .ADDR_W(ADDR_W), .DEV_W(DEV_W), .IDSEL_LSB(IDSEL_LSB)
    ) u_t0 (
        .in_addr  (req_addr),
        .out_addr (t0_addr)
    );

    always_comb begin
        case (d_route)
            RT_TYPE0: nxt_addr = t0_addr;
            RT_PASS:  nxt_addr = req_addr;
            default:  nxt_addr = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || !req_valid) begin
            rsp_q <= '{valid: 1'b0, route: RT_DROP, addr: '0, type1: 1'b0, err: 1'b0};
        end else begin
            rsp_q.valid <= 1'b1;
            rsp_q.route <= d_route;
            rsp_q.addr  <= nxt_addr;
            rsp_q.type1 <= (d_route == RT_PASS);
            rsp_q.err   <= d_err;
        end
    end

    assign rsp_valid = rsp_q.valid;
    assign rsp_route = rsp_q.route;
    assign rsp_addr  = rsp_q.addr;
    assign rsp_type1 = rsp_q.type1;
    assign rsp_err   = rsp_q.err;

endmodule

// File: rtl/cfgr_router_chk.sv
module cfgr_router_chk
    import cfgr_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic        req_type1,
    input logic [31:0] req_addr,
    input logic [7:0]  sec_bus,
    input logic        rsp_valid,
    input logic [1:0]  rsp_route,
    input logic [31:0] rsp_addr,
    input logic        rsp_type1,
    input logic        rsp_err
);

    assert_one_rsp_R9: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);

    assert_no_spurious_R9: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> (!rsp_valid && !rsp_err));

    assert_type0_local_R2: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_type1) |=> (rsp_route == RT_LOCAL && rsp_addr == '0 && !rsp_type1));

    assert_unset_drop_R1: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_type1 && sec_bus == '0) |=> (rsp_route == RT_DROP));

    assert_onehot_idsel_R6: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_route == RT_TYPE0) |-> ($countones(rsp_addr[31:11]) == 1 && rsp_addr[1:0] == 2'b00));

    assert_pass_same_R5: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_route == RT_PASS) |-> (rsp_addr == $past(req_addr) && rsp_type1));

    assert_err_drop_R7: assert property (@(posedge clk) disable iff (rst)
        rsp_err |-> (rsp_route == RT_DROP && rsp_addr == '0));

endmodule

bind cfgr_router cfgr_router_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_type1 (req_type1),
    .req_addr  (req_addr),
    .sec_bus   (sec_bus),
    .rsp_valid (rsp_valid),
    .rsp_route (rsp_route),
    .rsp_addr  (rsp_addr),
    .rsp_type1 (rsp_type1),
    .rsp_err   (rsp_err)
);

// File: tb/cfgr_router_tb.sv
module cfgr_router_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_type1 = 1'b0;
    logic [31:0] req_addr = '0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_sel = '0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  pri_bus, sec_bus, sub_bus;
    logic        rsp_valid, rsp_type1, rsp_err;
    logic [1:0]  rsp_route;
    logic [31:0] rsp_addr;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    logic [7:0] m_pri = '0, m_sec = '0, m_sub = '0;

    always #2 clk = ~clk;

    cfgr_router u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_type1(req_type1),
        .req_addr(req_addr), .bus_wr(bus_wr), .bus_sel(bus_sel), .bus_wdata(bus_wdata),
        .pri_bus(pri_bus), .sec_bus(sec_bus), .sub_bus(sub_bus),
        .rsp_valid(rsp_valid), .rsp_route(rsp_route), .rsp_addr(rsp_addr),
        .rsp_type1(rsp_type1), .rsp_err(rsp_err)
    );

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [1:0] exp_route(input logic t1, input logic [31:0] a);
        logic [7:0] b;
        b = a[23:16];
        if (!t1) return 2'd3;
        if (m_sec == 0 || b < m_sec || b > m_sub) return 2'd0;
        if (b == m_sec) return (a[15:11] > 5'd20) ? 2'd0 : 2'd1;
        return 2'd2;
    endfunction

    function automatic logic exp_err(input logic t1, input logic [31:0] a);
        return t1 && m_sec != 0 && a[23:16] == m_sec && m_sub >= m_sec && a[15:11] > 5'd20;
    endfunction

    function automatic logic [31:0] exp_addr(input logic t1, input logic [31:0] a);
        logic [1:0] r;
        r = exp_route(t1, a);
        if (r == 2'd2) return a;
        if (r == 2'd1) return (32'd1 << (11 + int'(a[15:11]))) | {21'd0, a[10:2], 2'b00};
        return 32'd0;
    endfunction

    task automatic wr_reg(input logic [1:0] s, input logic [7:0] v);
        bus_wr = 1'b1; bus_sel = s; bus_wdata = v;
        @(negedge clk);
        bus_wr = 1'b0;
        case (s)
            2'd0: m_pri = v;
            2'd1: m_sec = v;
            2'd2: m_sub = v;
            default: ;
        endcase
    endtask

    task automatic do_req(input string req, input logic t1, input logic [31:0] a);
        req_valid = 1'b1; req_type1 = t1; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        check(req, "valid", {31'd0, rsp_valid}, 32'd1);
        check(req, "route", {30'd0, rsp_route}, {30'd0, exp_route(t1, a)});
        check(req, "addr", rsp_addr, exp_addr(t1, a));
        check(req, "type1", {31'd0, rsp_type1}, {31'd0, exp_route(t1, a) == 2'd2});
        check(req, "err", {31'd0, rsp_err}, {31'd0, exp_err(t1, a)});
    endtask

    function automatic logic [31:0] t1a(input logic [7:0] b, input logic [4:0] d, input logic [2:0] f, input logic [5:0] r);
        return {8'h00, b, d, f, r, 2'b01};
    endfunction

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin : stim
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset values
        check("R1", "pri", {24'd0, pri_bus}, 32'd0);
        check("R1", "sec", {24'd0, sec_bus}, 32'd0);
        check("R1", "sub", {24'd0, sub_bus}, 32'd0);
        check("R1", "valid", {31'd0, rsp_valid}, 32'd0);
        do_req("R1", 1'b1, t1a(8'd0, 5'd0, 3'd0, 6'd0));
        do_req("R1", 1'b1, t1a(8'd3, 5'd2, 3'd0, 6'd1));
        // R10: programming and select 3 ignored
        wr_reg(2'd0, 8'd1); wr_reg(2'd1, 8'd3); wr_reg(2'd2, 8'd4);
        bus_wr = 1'b1; bus_sel = 2'd3; bus_wdata = 8'hAA;
        @(negedge clk);
        bus_wr = 1'b0;
        check("R10", "pri", {24'd0, pri_bus}, 32'd1);
        check("R10", "sec", {24'd0, sec_bus}, 32'd3);
        check("R10", "sub", {24'd0, sub_bus}, 32'd4);
        // R4 / R5 / R3 with 1,3,4
        do_req("R4", 1'b1, t1a(8'd3, 5'd1, 3'd5, 6'h2A));
        do_req("R5", 1'b1, t1a(8'd4, 5'd7, 3'd1, 6'h11));
        do_req("R3", 1'b1, t1a(8'd2, 5'd1, 3'd0, 6'd0));
        do_req("R3", 1'b1, t1a(8'd5, 5'd1, 3'd0, 6'd0));
        // R6 device ends, R7 error
        do_req("R6", 1'b1, t1a(8'd3, 5'd0, 3'd7, 6'h3F));
        do_req("R6", 1'b1, t1a(8'd3, 5'd20, 3'd2, 6'h05));
        do_req("R7", 1'b1, t1a(8'd3, 5'd21, 3'd0, 6'd0));
        do_req("R7", 1'b1, t1a(8'd3, 5'd31, 3'd0, 6'd0));
        // R2 Type 0 local
        do_req("R2", 1'b0, 32'h0000_1234);
        do_req("R2", 1'b0, t1a(8'd3, 5'd1, 3'd0, 6'd0));
        // R9 idle cycle
        @(negedge clk);
        check("R9", "valid", {31'd0, rsp_valid}, 32'd0);
        check("R9", "err", {31'd0, rsp_err}, 32'd0);
        // R8 open-ended range
        wr_reg(2'd1, 8'd1); wr_reg(2'd2, 8'hFF);
        do_req("R8", 1'b1, t1a(8'hFF, 5'd3, 3'd0, 6'd0));
        do_req("R8", 1'b1, t1a(8'd1, 5'd3, 3'd0, 6'd0));
        do_req("R8", 1'b1, t1a(8'd0, 5'd3, 3'd0, 6'd0));
        // R3 highest below downstream
        wr_reg(2'd1, 8'd5); wr_reg(2'd2, 8'd4);
        do_req("R3", 1'b1, t1a(8'd5, 5'd0, 3'd0, 6'd0));
        // R1 downstream zero again
        wr_reg(2'd1, 8'd0); wr_reg(2'd2, 8'd9);
        do_req("R1", 1'b1, t1a(8'd0, 5'd0, 3'd0, 6'd0));
        // random mix
        for (int i = 0; i < 600; i++) begin
            logic [31:0] a;
            logic t1;
            if (i % 40 == 0) begin
                wr_reg(2'd1, 8'($urandom_range(0, 6)));
                wr_reg(2'd2, ($urandom_range(0, 4) == 0) ? 8'hFF : 8'($urandom_range(0, 9)));
            end
            a = $urandom;
            a[23:16] = ($urandom_range(0, 9) == 0) ? 8'($urandom) : 8'($urandom_range(0, 10));
            t1 = ($urandom_range(0, 9) != 0);
            if (t1) a[1:0] = 2'b01;
            if ($urandom_range(0, 7) == 0) begin
                @(negedge clk);
                check("R9", "idle", {31'd0, rsp_valid}, 32'd0);
            end
            do_req("R4", t1, a);
        end
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule